// File: doc/BRIEF.md
# Flash command mode state machine

This block is the control sequencer of an embedded flash array. It takes host write cycles on an 8-bit data bus and turns them into commands. The address is not used, so a command byte acts the same at any location. It tracks which mode the array is in: normal array reads, identifier/protection readout, the two setup steps that come before a program or an erase, the program, bulk-erase and sector-erase operations, a recovery delay, and an error state. Cycle counters stand in for the length of each operation.

The host watches a ready/busy line and an error bit. The error bit is the value the array drives on data bit 5 when an operation fails. The reset command is the byte F0h. It does not act the same in every mode. During a program or a bulk erase it has no effect. During a sector erase it cancels the erase. In the identifier mode, the error state and the setup steps it is the way back to reading. Whenever it is accepted, the machine first spends a settling delay with ready low and then returns to array reads.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset the mode is ARRAY (code 0), ready_o is 1 and err_o is 0.
- R2: Mode codes are ARRAY=0, IDENT=1, PGM_SETUP=2, ERS_SETUP=3, PGM=4, BULK=5, SECTOR=6, SETTLE=7 and FAULT=8. ready_o is 0 in codes 4 to 7 and 1 otherwise. err_o is 1 only in FAULT.
- R3: In ARRAY mode, a write of 90h enters IDENT, A0h enters PGM_SETUP and 80h enters ERS_SETUP. Any other byte except F0h is ignored.
- R4: In PGM_SETUP, any byte other than F0h starts PGM. PGM lasts PGM_CYC cycles and then returns to ARRAY.
- R5: In ERS_SETUP, 10h starts BULK (BULK_CYC cycles) and 30h starts SECTOR (SECT_CYC cycles). Any other byte except F0h returns to ARRAY.
- R6: A write of F0h in ARRAY, IDENT, either setup mode or FAULT enters SETTLE. SETTLE holds ready_o low for SETTLE_CYC cycles and then returns to ARRAY.
- R7: In PGM and BULK, every write, F0h included, is ignored and the operation runs for its full length.
- R8: In SECTOR, a write of F0h aborts the erase and enters SETTLE in the next cycle.
- R9: array_fail high in PGM, BULK or SECTOR enters FAULT. FAULT holds err_o high and ignores every write except F0h.
- R10: In IDENT and in SETTLE, writes other than F0h are ignored. In SETTLE, F0h is ignored as well.
- R11: Priority within one cycle: array_fail wins over F0h and over the last cycle of an operation, and F0h in SECTOR wins over the last cycle of the erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_data | input | 8 | Command byte of the write |
| array_fail | input | 1 | Failure report from the array during an operation |
| mode_o | output | 4 | Current mode code (R2) |
| ready_o | output | 1 | 1 = ready, 0 = busy |
| err_o | output | 1 | Operation error bit (data bit 5 status) |

## Verification
Two events can fall in the same cycle. A host reset can arrive on the final count of an operation, or an array failure can coincide with either the reset or the final count. The bench places an F0h write on exactly the last cycle of a sector erase and of a program. It also raises array_fail in the same cycle as an F0h write during a sector erase, and on the final program cycle. A behavioural model that encodes the R11 priority order is compared with mode, ready and error on every clock, so it catches a wrong winner in the very cycle that follows.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    M_ARRAY  = 4'd0,
    M_IDENT  = 4'd1,
    M_PSETUP = 4'd2,
    M_ESETUP = 4'd3,
    M_PGM    = 4'd4,
    M_BULK   = 4'd5,
    M_SECTOR = 4'd6,
    M_SETTLE = 4'd7,
    M_FAULT  = 4'd8
  } mode_t;

  typedef enum logic [2:0] {
    C_NONE,
    C_RESET,
    C_IDENT,
    C_PGM,
    C_ERASE,
    C_BULK,
    C_SECTOR,
    C_OTHER
  } cmd_t;

  localparam logic [7:0] OP_RESET  = 8'hF0;
  localparam logic [7:0] OP_IDENT  = 8'h90;
  localparam logic [7:0] OP_PGM    = 8'hA0;
  localparam logic [7:0] OP_ERASE  = 8'h80;
  localparam logic [7:0] OP_BULK   = 8'h10;
  localparam logic [7:0] OP_SECTOR = 8'h30;

endpackage

// File: rtl/flash_rst_sync.sv
module flash_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output cmd_t          cmd
);

  logic [7:0] byte_v;

  assign byte_v = wr_data[7:0];

  always_comb begin
    cmd = C_NONE;
    if (wr_en) begin
      unique case (byte_v)
        OP_RESET:  cmd = C_RESET;
        OP_IDENT:  cmd = C_IDENT;
        OP_PGM:    cmd = C_PGM;
        OP_ERASE:  cmd = C_ERASE;
        OP_BULK:   cmd = C_BULK;
        OP_SECTOR: cmd = C_SECTOR;
        default:   cmd = C_OTHER;
      endcase
    end
  end

endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    if (load) begin
      cnt_d = load_val;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/flash_mode_ctrl.sv
module flash_mode_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int PGM_CYC    = 6,
  parameter int BULK_CYC   = 20,
  parameter int SECT_CYC   = 12,
  parameter int SETTLE_CYC = 4,
  parameter int CW         = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cmd_t          cmd,
  input  logic          array_fail,
  input  logic          done,
  output mode_t         mode_q,
  output logic          load,
  output logic [CW-1:0] load_val
);

  mode_t mode_d;
  logic  busy_next;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      M_ARRAY: begin
        unique case (cmd)
          C_RESET: mode_d = M_SETTLE;
          C_IDENT: mode_d = M_IDENT;
          C_PGM:   mode_d = M_PSETUP;
          C_ERASE: mode_d = M_ESETUP;
          default: mode_d = M_ARRAY;
        endcase
      end
      M_IDENT: begin
        if (cmd == C_RESET) mode_d = M_SETTLE;
      end
      M_PSETUP: begin
        if (cmd == C_RESET) mode_d = M_SETTLE;
        else if (cmd != C_NONE) mode_d = M_PGM;
      end
      M_ESETUP: begin
        unique case (cmd)
          C_NONE:   mode_d = M_ESETUP;
          C_RESET:  mode_d = M_SETTLE;
          C_BULK:   mode_d = M_BULK;
          C_SECTOR: mode_d = M_SECTOR;
          default:  mode_d = M_ARRAY;
        endcase
      end
      M_PGM, M_BULK: begin
        if (array_fail) mode_d = M_FAULT;
        else if (done) mode_d = M_ARRAY;
      end
      M_SECTOR: begin
        if (array_fail) mode_d = M_FAULT;
        else if (cmd == C_RESET) mode_d = M_SETTLE;
        else if (done) mode_d = M_ARRAY;
      end
      M_SETTLE: begin
        if (done) mode_d = M_ARRAY;
      end
      M_FAULT: begin
        if (cmd == C_RESET) mode_d = M_SETTLE;
      end
      default: mode_d = M_ARRAY;
    endcase
  end

  always_comb begin
    busy_next = 1'b1;
    load_val  = '0;
    unique case (mode_d)
      M_PGM:    load_val = CW'(PGM_CYC - 1);
      M_BULK:   load_val = CW'(BULK_CYC - 1);
      M_SECTOR: load_val = CW'(SECT_CYC - 1);
      M_SETTLE: load_val = CW'(SETTLE_CYC - 1);
      default:  busy_next = 1'b0;
    endcase
  end

  assign load = busy_next && (mode_d != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_ARRAY;
    end else begin
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int PGM_CYC    = 6,
  parameter int BULK_CYC   = 20,
  parameter int SECT_CYC   = 12,
  parameter int SETTLE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       array_fail,
  output logic [3:0] mode_o,
  output logic       ready_o,
  output logic       err_o
);

  localparam int MAX_A = (PGM_CYC > BULK_CYC) ? PGM_CYC : BULK_CYC;
  localparam int MAX_B = (SECT_CYC > SETTLE_CYC) ? SECT_CYC : SETTLE_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  logic          rst_n_sync;
  cmd_t          cmd;
  mode_t         mode_q;
  logic          load;
  logic [CW-1:0] load_val;
  logic          done;

  flash_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  flash_cmd_decode #(.DW(8)) u_dec (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cmd     (cmd)
  );

  flash_mode_ctrl #(
    .PGM_CYC    (PGM_CYC),
    .BULK_CYC   (BULK_CYC),
    .SECT_CYC   (SECT_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .CW         (CW)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .cmd        (cmd),
    .array_fail (array_fail),
    .done       (done),
    .mode_q     (mode_q),
    .load       (load),
    .load_val   (load_val)
  );

  flash_op_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .load     (load),
    .load_val (load_val),
    .done     (done)
  );

  assign mode_o  = mode_q;
  assign ready_o = !(mode_q inside {M_PGM, M_BULK, M_SECTOR, M_SETTLE});
  assign err_o   = (mode_q == M_FAULT);

endmodule

// File: rtl/flash_cmd_fsm_chk.sv
module flash_cmd_fsm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       array_fail,
  input logic [3:0] mode_o,
  input logic       ready_o,
  input logic       err_o
);

  logic f0_wr;
  assign f0_wr = wr_en && (wr_data == 8'hF0);

  // R2: mode code always legal
  assert_mode_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o <= 4'd8);

  // R6: settle shows busy
  assert_settle_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 4'd7) |-> !ready_o);

  // R7: reset byte cannot interrupt a program
  assert_pgm_no_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 4'd4 && f0_wr && !array_fail) |=> (mode_o == 4'd4 || mode_o == 4'd0));

  // R7: reset byte cannot interrupt a bulk erase
  assert_bulk_no_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 4'd5 && f0_wr && !array_fail) |=> (mode_o == 4'd5 || mode_o == 4'd0));

  // R8: reset byte aborts a sector erase
  assert_sector_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 4'd6 && f0_wr && !array_fail) |=> (mode_o == 4'd7));

  // R9: error bit holds until a reset byte
  assert_err_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !f0_wr) |=> err_o);

  // R9: error bit rises only after a failure report
  assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> $past(array_fail));

  // R11: failure wins over everything in an operation
  assert_fail_prio_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_o == 4'd4 || mode_o == 4'd5 || mode_o == 4'd6) && array_fail) |=> err_o);

endmodule

bind flash_cmd_fsm flash_cmd_fsm_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .array_fail (array_fail),
  .mode_o     (mode_o),
  .ready_o    (ready_o),
  .err_o      (err_o)
);

// File: tb/flash_cmd_fsm_test.sv
`timescale 1ns/1ps
module flash_cmd_fsm_test;

  localparam int PGM_CYC    = 6;
  localparam int BULK_CYC   = 20;
  localparam int SECT_CYC   = 12;
  localparam int SETTLE_CYC = 4;
  localparam int WATCHDOG   = 100000;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       array_fail;
  logic [3:0] mode_o;
  logic       ready_o;
  logic       err_o;

  int    tests_run;
  int    tests_failed;
  int    cyc;
  string cur_req;

  int    m_mode;
  int    m_left;

  flash_cmd_fsm #(
    .PGM_CYC    (PGM_CYC),
    .BULK_CYC   (BULK_CYC),
    .SECT_CYC   (SECT_CYC),
    .SETTLE_CYC (SETTLE_CYC)
  ) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .array_fail (array_fail),
    .mode_o     (mode_o),
    .ready_o    (ready_o),
    .err_o      (err_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Behavioural reference: mode number and remaining cycles of a timed mode
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0;
      m_left = 0;
    end else begin
      bit rst_b;
      rst_b = wr_en && (wr_data == 8'hF0);
      case (m_mode)
        0: if (wr_en) begin
             if (rst_b) begin m_mode = 7; m_left = SETTLE_CYC; end
             else if (wr_data == 8'h90) m_mode = 1;
             else if (wr_data == 8'hA0) m_mode = 2;
             else if (wr_data == 8'h80) m_mode = 3;
           end
        1, 8: if (rst_b) begin m_mode = 7; m_left = SETTLE_CYC; end
        2: if (wr_en) begin
             if (rst_b) begin m_mode = 7; m_left = SETTLE_CYC; end
             else begin m_mode = 4; m_left = PGM_CYC; end
           end
        3: if (wr_en) begin
             if (rst_b) begin m_mode = 7; m_left = SETTLE_CYC; end
             else if (wr_data == 8'h10) begin m_mode = 5; m_left = BULK_CYC; end
             else if (wr_data == 8'h30) begin m_mode = 6; m_left = SECT_CYC; end
             else m_mode = 0;
           end
        4, 5, 6: begin
             if (array_fail) m_mode = 8;
             else if (m_mode == 6 && rst_b) begin m_mode = 7; m_left = SETTLE_CYC; end
             else begin
               m_left--;
               if (m_left == 0) m_mode = 0;
             end
           end
        7: begin
             m_left--;
             if (m_left == 0) m_mode = 0;
           end
        default: m_mode = 0;
      endcase
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      int  exp_ready;
      int  exp_err;
      exp_ready = (m_mode >= 4 && m_mode <= 7) ? 0 : 1;
      exp_err   = (m_mode == 8) ? 1 : 0;
      tests_run++;
      if (int'(mode_o) != m_mode || int'(ready_o) != exp_ready || int'(err_o) != exp_err) begin
        tests_failed++;
        $display("FAIL %s: mode/ready/err actual %0d/%0d/%0d expected %0d/%0d/%0d",
                 cur_req, mode_o, ready_o, err_o, m_mode, exp_ready, exp_err);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      tests_failed++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  task automatic cycle(input logic we, input logic [7:0] d, input logic f);
    @(negedge clk);
    wr_en      = we;
    wr_data    = d;
    array_fail = f;
    @(negedge clk);
    wr_en      = 1'b0;
    wr_data    = 8'h00;
    array_fail = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    cycle(1'b1, d, 1'b0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // cycle() leaves its strobe on for one edge and returns one negedge later;
  // idle(n) then lets n further edges pass before the next strobe is sampled.
  initial begin
    tests_run    = 0;
    tests_failed = 0;
    cyc          = 0;
    wr_en        = 1'b0;
    wr_data      = 8'h00;
    array_fail   = 1'b0;
    rst_n        = 1'b0;
    cur_req      = "R1";
    idle(3);
    rst_n = 1'b1;
    idle(4);

    cur_req = "R3";
    wr(8'h33); idle(1);
    wr(8'h90); idle(1);

    cur_req = "R10";
    wr(8'h12); wr(8'hA0); idle(1);

    cur_req = "R6";
    wr(8'hF0); idle(SETTLE_CYC + 2);

    cur_req = "R4";
    wr(8'hA0); wr(8'h55); idle(PGM_CYC + 2);

    cur_req = "R5";
    wr(8'h80); wr(8'h77); idle(1);
    wr(8'h80); wr(8'h10); idle(BULK_CYC + 2);

    cur_req = "R7";
    wr(8'hA0); wr(8'h00); idle(1); wr(8'hF0); wr(8'h90); idle(PGM_CYC);
    wr(8'h80); wr(8'h10); idle(5); wr(8'hF0); idle(3); wr(8'hF0); idle(BULK_CYC);

    cur_req = "R8";
    wr(8'h80); wr(8'h30); idle(3); wr(8'hF0); idle(SETTLE_CYC + 2);

    cur_req = "R10";
    wr(8'hF0); wr(8'h90); wr(8'hF0); idle(SETTLE_CYC + 2);

    cur_req = "R9";
    wr(8'h80); wr(8'h30); idle(2); cycle(1'b0, 8'h00, 1'b1); idle(3);
    wr(8'h90); wr(8'hA0); idle(2); wr(8'hF0); idle(SETTLE_CYC + 2);
    wr(8'hA0); wr(8'h01); idle(2); cycle(1'b0, 8'h00, 1'b1); idle(2);
    wr(8'hF0); idle(SETTLE_CYC + 2);
    wr(8'h80); wr(8'h10); idle(4); cycle(1'b0, 8'h00, 1'b1); idle(2);
    wr(8'hF0); idle(SETTLE_CYC + 2);

    cur_req = "R11";
    // F0h on the last sector-erase cycle
    wr(8'h80); wr(8'h30); idle(SECT_CYC - 2); wr(8'hF0); idle(SETTLE_CYC + 2);
    // failure together with F0h during sector erase
    wr(8'h80); wr(8'h30); idle(4); cycle(1'b1, 8'hF0, 1'b1); idle(2);
    wr(8'hF0); idle(SETTLE_CYC + 2);
    // failure on the last program cycle
    wr(8'hA0); wr(8'h02); idle(PGM_CYC - 2); cycle(1'b0, 8'h00, 1'b1); idle(2);
    wr(8'hF0); idle(SETTLE_CYC + 2);
    // F0h on the last program cycle is ignored
    wr(8'hA0); wr(8'h03); idle(PGM_CYC - 2); wr(8'hF0); idle(3);

    cur_req = "R1";
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(4);

    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule